// File: doc/BRIEF.md
# Clock Control Register File

This block is a bank of 32-bit control words that software reaches through a 4 KiB window on a simple request bus. The words hold clock gates, source selections, divider settings, peripheral reset holds, watchdog reset routing and reset-control settings. Each word sits at a word index equal to the byte address shifted right by two. Every word comes up from cold reset with a fixed value.

Most words are plain storage. A few have their own rules. The four PLL control words adjust their lock and loss-of-lock flags according to the power-down bit that is written. The software-reset word can be written, but it keeps nothing and cannot be read. Two free-running counters are read-only: a 25 MHz tick count and a count of elapsed seconds. A request that is unaligned, out of range, or breaks an access rule has no effect and raises a one-cycle error pulse. Read data is registered and returned one cycle after the request.

Top module: `clkctl_regfile`

## Requirements
- R1: After cold reset, reads return these values at word index: 0 ffffffff, 1 004aaaaa, 2 5413f855, 3 80222101, 4 80202101, 8 00001000, 9 80000000, 10 ffffffff, 11 aa4f8f9f, 12 ffffffff, 13 03000000, 14 to 16 ffffffff, 17 00000003, 21 80c02105, 23 04000003, 24 81228606, 25 000000c8. Every other storage index (6, 7, 18, 19, 20, 22) returns 0.
- R2: The word index is reqAddr[11:2]. A write to a plain storage index (including the spare indices 6 and 7) stores the full 32-bit word, and a later read returns it.
- R3: rspValid is high for exactly the cycle after a read request, with rspRdata valid in that cycle. Write requests never raise rspValid.
- R4: Index 5 (software reset) accepts writes without error and stores nothing. A read of it returns 0 and raises rspErr.
- R5: On PLL indices 3, 4, 21 and 24, a write with bit 12 (power-down) set stores the data with bit 31 (lock) cleared and bit 30 (lock lost) set.
- R6: On PLL indices, a write with bit 12 clear stores the data with bit 31 set. Bit 30 keeps its old value unless the write carries a 1 in bit 30, which clears it.
- R7: Index 27 returns a tick count that advances by CNT_STEP (16) every SUB_TICK_CYCLES clocks and wraps to 0 on reaching CNT_WRAP. Its low four bits are always 0.
- R8: Index 26 returns a seconds count that increments each time the tick count wraps.
- R9: Writes to index 26 or 27 are ignored and raise rspErr.
- R10: Any index of 28 or above returns 0 on read, drops writes, and raises rspErr.
- R11: A request with reqAddr[1:0] not zero has no effect, returns 0 if it is a read, and raises rspErr.
- R12: rspErr is high only in the cycle after a faulting request. Legal requests leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low cold reset |
| reqValid | input | 1 | Request strobe, one cycle per access |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 12 | Byte address inside the window |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid, one cycle after a read |
| rspRdata | output | 32 | Registered read data |
| rspErr | output | 1 | One-cycle fault pulse for the previous request |

## Verification
The bench concentrates on the PLL flag rules, because a design that overwrote the lock-lost flag directly from the data would lose the sticky bit on a normal-mode write. It reads the counters at exactly spaced cycles so that a wrong step, a wrong wrap point or a missed seconds increment shows up as a wrong difference. Unaligned and out-of-range writes are followed by read-backs of the word they might have hit, which catches a decoder that drops address bits. Reads of the write-only word and writes to the counters confirm that both the zero data and the error pulse appear.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DW        = 32;
  localparam int ADDR_W    = 12;
  localparam int NUM_REGS  = 28;
  localparam int IX_SEL_W  = $clog2(NUM_REGS);

  localparam int IX_PLL0   = 3;
  localparam int IX_PLL1   = 4;
  localparam int IX_SWRST  = 5;
  localparam int IX_PLL2   = 21;
  localparam int IX_PLLG   = 24;
  localparam int IX_SECS   = 26;
  localparam int IX_TICKS  = 27;

  localparam int PLL_LOCK  = 31;
  localparam int PLL_LOST  = 30;
  localparam int PLL_PDOWN = 12;

  typedef struct packed {
    logic                wrEn;
    logic                rdEn;
    logic [IX_SEL_W-1:0] idx;
    logic                fault;
  } ctlStrobe_t;

  function automatic logic isPllIdx(int idx);
    return (idx == IX_PLL0) || (idx == IX_PLL1) || (idx == IX_PLL2) || (idx == IX_PLLG);
  endfunction

  function automatic logic [DW-1:0] coldValue(int idx);
    case (idx)
      0, 10, 12, 14, 15, 16: return 32'hffff_ffff;
      1:  return 32'h004a_aaaa;
      2:  return 32'h5413_f855;
      3:  return 32'h8022_2101;
      4:  return 32'h8020_2101;
      8:  return 32'h0000_1000;
      9:  return 32'h8000_0000;
      11: return 32'haa4f_8f9f;
      13: return 32'h0300_0000;
      17: return 32'h0000_0003;
      21: return 32'h80c0_2105;
      23: return 32'h0400_0003;
      24: return 32'h8122_8606;
      25: return 32'h0000_00c8;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] pllMerge(logic [DW-1:0] oldVal, logic [DW-1:0] wrVal);
    logic [DW-1:0] nv;
    nv = wrVal;
    if (wrVal[PLL_PDOWN]) begin
      nv[PLL_LOCK] = 1'b0;
      nv[PLL_LOST] = 1'b1;
    end else begin
      nv[PLL_LOCK] = 1'b1;
      nv[PLL_LOST] = oldVal[PLL_LOST] & ~wrVal[PLL_LOST];
    end
    return nv;
  endfunction
endpackage

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output ctlStrobe_t        strobe,
  output logic              rspValid,
  output logic              rspErr
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic aligned, inRange, isWriteOnly, isReadOnly, fault;

  assign wordIdx     = reqAddr[ADDR_W-1:2];
  assign aligned     = (reqAddr[1:0] == 2'b00);
  assign inRange     = (wordIdx < IDX_W'(NUM_REGS));
  assign isWriteOnly = (wordIdx == IDX_W'(IX_SWRST));
  assign isReadOnly  = (wordIdx == IDX_W'(IX_SECS)) || (wordIdx == IDX_W'(IX_TICKS));

  always_comb begin
    fault = reqValid && (!aligned || !inRange ||
                         (!reqWrite && isWriteOnly) ||
                         (reqWrite && isReadOnly));
    strobe.fault = fault;
    strobe.wrEn  = reqValid && reqWrite && !fault && !isWriteOnly;
    strobe.rdEn  = reqValid && !reqWrite && !fault;
    strobe.idx   = wordIdx[IX_SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid && !reqWrite;
      rspErr   <= fault;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !reqWrite)); // R3
  AST_ERR_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> $past(reqValid)); // R12
  AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fault |-> !strobe.wrEn && !strobe.rdEn); // R10
endmodule

// File: rtl/clkctl_counters.sv
module clkctl_counters
  import clkctl_pkg::*;
#(
  parameter int SUB_TICK_CYCLES = 64,
  parameter int CNT_WRAP        = 25000000,
  parameter int CNT_STEP        = 16
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [DW-1:0] ticksOut,
  output logic [DW-1:0] secsOut
);
  localparam int SUB_W  = (SUB_TICK_CYCLES > 1) ? $clog2(SUB_TICK_CYCLES) : 1;
  localparam int TICK_W = $clog2(CNT_WRAP);

  logic [SUB_W-1:0]  subQ;
  logic [TICK_W-1:0] ticksQ;
  logic [TICK_W:0]   ticksSum;
  logic [DW-1:0]     secsQ;
  logic              tickEn, wrapNow;

  assign tickEn   = (subQ == SUB_W'(SUB_TICK_CYCLES - 1));
  assign ticksSum = {1'b0, ticksQ} + (TICK_W + 1)'(CNT_STEP);
  assign wrapNow  = (ticksSum >= (TICK_W + 1)'(CNT_WRAP));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subQ   <= '0;
      ticksQ <= '0;
      secsQ  <= '0;
    end else begin
      subQ <= tickEn ? '0 : subQ + 1'b1;
      if (tickEn) begin
        ticksQ <= wrapNow ? '0 : ticksSum[TICK_W-1:0];
        if (wrapNow) secsQ <= secsQ + 1'b1;
      end
    end
  end

  assign ticksOut = DW'(ticksQ);
  assign secsOut  = secsQ;

  AST_TICKS_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ticksOut < DW'(CNT_WRAP)); // R7
  AST_TICKS_STEP_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (ticksOut % DW'(CNT_STEP)) == 0); // R7
  AST_SECS_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(secsOut) |-> ticksOut == '0); // R8
endmodule

// File: rtl/clkctl_datapath.sv
module clkctl_datapath
  import clkctl_pkg::*;
#(
  parameter int SUB_TICK_CYCLES = 64,
  parameter int CNT_WRAP        = 25000000,
  parameter int CNT_STEP        = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic [DW-1:0] reqWdata,
  output logic [DW-1:0] rspRdata
);
  logic [DW-1:0] regQ [NUM_REGS];
  logic [DW-1:0] ticksVal, secsVal, rdNext;

  clkctl_counters #(
    .SUB_TICK_CYCLES(SUB_TICK_CYCLES),
    .CNT_WRAP       (CNT_WRAP),
    .CNT_STEP       (CNT_STEP)
  ) counters_i (
    .clk     (clk),
    .rstN    (rstN),
    .ticksOut(ticksVal),
    .secsOut (secsVal)
  );

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : gReg
    if (gi == IX_SWRST || gi == IX_SECS || gi == IX_TICKS) begin : gNone
      assign regQ[gi] = '0;
    end else if (isPllIdx(gi)) begin : gPll
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regQ[gi] <= coldValue(gi);
        else if (strobe.wrEn && strobe.idx == IX_SEL_W'(gi))
          regQ[gi] <= pllMerge(regQ[gi], reqWdata);
      end
      AST_PLL_LOCK_VS_PDOWN: assert property (@(posedge clk) disable iff (!rstN)
        regQ[gi][PLL_LOCK] == !regQ[gi][PLL_PDOWN]); // R5
      AST_PLL_LOST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        ($past(regQ[gi][PLL_LOST]) && !regQ[gi][PLL_PDOWN] &&
         !$past(reqWdata[PLL_LOST])) |-> regQ[gi][PLL_LOST]); // R6
    end else begin : gPlain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regQ[gi] <= coldValue(gi);
        else if (strobe.wrEn && strobe.idx == IX_SEL_W'(gi))
          regQ[gi] <= reqWdata;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (strobe.rdEn) begin
      if (strobe.idx == IX_SEL_W'(IX_TICKS))     rdNext = ticksVal;
      else if (strobe.idx == IX_SEL_W'(IX_SECS)) rdNext = secsVal;
      else                                       rdNext = regQ[strobe.idx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspRdata <= '0;
    else       rspRdata <= rdNext;
  end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
  import clkctl_pkg::*;
#(
  parameter int SUB_TICK_CYCLES = 64,
  parameter int CNT_WRAP        = 25000000,
  parameter int CNT_STEP        = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [11:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspRdata,
  output logic        rspErr
);
  ctlStrobe_t strobe;

  clkctl_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .strobe  (strobe),
    .rspValid(rspValid),
    .rspErr  (rspErr)
  );

  clkctl_datapath #(
    .SUB_TICK_CYCLES(SUB_TICK_CYCLES),
    .CNT_WRAP       (CNT_WRAP),
    .CNT_STEP       (CNT_STEP)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqWdata(reqWdata),
    .rspRdata(rspRdata)
  );

  AST_FAULT_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> rspRdata == '0); // R10
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> rspRdata == '0); // R3
endmodule

// File: tb/clkctl_regfile_tb_top.sv
module clkctl_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        rspErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  clkctl_regfile #(.SUB_TICK_CYCLES(2), .CNT_WRAP(64), .CNT_STEP(16)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspRdata(rspRdata), .rspErr(rspErr)
  );

  function automatic logic [31:0] expectCold(int idx);
    case (idx)
      0, 10, 12, 14, 15, 16: return 32'hffffffff;
      1: return 32'h004aaaaa;   2: return 32'h5413f855;
      3: return 32'h80222101;   4: return 32'h80202101;
      8: return 32'h00001000;   9: return 32'h80000000;
      11: return 32'haa4f8f9f;  13: return 32'h03000000;
      17: return 32'h00000003;  21: return 32'h80c02105;
      23: return 32'h04000003;  24: return 32'h81228606;
      25: return 32'h000000c8;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [11:0] addr, output logic [31:0] data,
                        output logic vld, output logic err);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = addr;
    @(negedge clk);
    data = rspRdata; vld = rspValid; err = rspErr;
    reqValid = 1'b0;
  endtask

  task automatic doWrite(input logic [11:0] addr, input logic [31:0] data,
                         output logic vld, output logic err);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = addr; reqWdata = data;
    @(negedge clk);
    vld = rspValid; err = rspErr;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d; logic v, e;
    check("R3 reset rspValid", 32'(rspValid), 0);
    check("R12 reset rspErr", 32'(rspErr), 0);
    for (int i = 0; i < 26; i++) begin
      if (i == 5) continue;
      doRead(12'(i * 4), d, v, e);
      check($sformatf("R1 cold value idx %0d", i), d, expectCold(i));
    end
  endtask

  task automatic testPlainRw();
    logic [31:0] d; logic v, e;
    doWrite(12'h004, 32'h12345678, v, e);
    check("R3 write gives no rspValid", 32'(v), 0);
    check("R12 legal write no err", 32'(e), 0);
    doRead(12'h004, d, v, e);
    check("R2 readback idx 1", d, 32'h12345678);
    check("R3 read gives rspValid", 32'(v), 1);
    check("R12 legal read no err", 32'(e), 0);
    doWrite(12'h01C, 32'hcafe0007, v, e);
    doWrite(12'h058, 32'h0badf00d, v, e);
    doRead(12'h01C, d, v, e);
    check("R2 readback spare idx 7", d, 32'hcafe0007);
    doRead(12'h058, d, v, e);
    check("R2 readback idx 22", d, 32'h0badf00d);
    doRead(12'h000, d, v, e);
    check("R2 neighbour idx 0 untouched", d, 32'hffffffff);
  endtask

  task automatic testSwReset();
    logic [31:0] d; logic v, e;
    doWrite(12'h014, 32'h000000ff, v, e);
    check("R4 swreset write no err", 32'(e), 0);
    doRead(12'h014, d, v, e);
    check("R4 swreset reads 0", d, 0);
    check("R4 swreset read err", 32'(e), 1);
    check("R3 faulting read still rspValid", 32'(v), 1);
  endtask

  task automatic testPll();
    logic [31:0] d; logic v, e;
    doWrite(12'h00C, 32'h80001234, v, e);
    doRead(12'h00C, d, v, e);
    check("R5 power-down clears lock sets lost", d, 32'h40001234);
    doWrite(12'h00C, 32'h00222101, v, e);
    doRead(12'h00C, d, v, e);
    check("R6 normal write keeps lost flag", d, 32'hc0222101);
    doWrite(12'h00C, 32'h40222101, v, e);
    doRead(12'h00C, d, v, e);
    check("R6 writing 1 clears lost flag", d, 32'h80222101);
    doWrite(12'h060, 32'h00001000, v, e);
    doRead(12'h060, d, v, e);
    check("R5 power-down on idx 24", d, 32'h40001000);
    doWrite(12'h054, 32'h40000005, v, e);
    doRead(12'h054, d, v, e);
    check("R6 lost clear stays clear idx 21", d, 32'h80000005);
  endtask

  task automatic testTicks();
    logic [31:0] a, b; logic v, e;
    doRead(12'h06C, a, v, e);
    repeat (5) @(negedge clk);
    doRead(12'h06C, b, v, e);
    check("R7 tick low bits zero", a & 32'hf, 0);
    check("R7 tick below wrap", 32'(a < 64), 1);
    check("R7 tick delta over 6 cycles", (b - a) & 32'h3f, 48);
  endtask

  task automatic testSeconds();
    logic [31:0] a, b; logic v, e;
    doRead(12'h068, a, v, e);
    repeat (15) @(negedge clk);
    doRead(12'h068, b, v, e);
    check("R8 seconds advance 2 per 16 cycles", b - a, 2);
  endtask

  task automatic testReadOnly();
    logic [31:0] a, b; logic v, e;
    doRead(12'h068, a, v, e);
    doWrite(12'h068, 32'h0, v, e);
    check("R9 seconds write err", 32'(e), 1);
    repeat (6) @(negedge clk);
    doRead(12'h068, b, v, e);
    check("R9 seconds write ignored", b - a, 1);
    doWrite(12'h06C, 32'h00000005, v, e);
    check("R9 tick write err", 32'(e), 1);
    doRead(12'h06C, a, v, e);
    check("R9 tick write ignored", a & 32'hf, 0);
  endtask

  task automatic testOutOfRange();
    logic [31:0] d; logic v, e;
    doWrite(12'h070, 32'hdeadbeef, v, e);
    check("R10 write idx 28 err", 32'(e), 1);
    doRead(12'h070, d, v, e);
    check("R10 read idx 28 data", d, 0);
    check("R10 read idx 28 err", 32'(e), 1);
    doWrite(12'h804, 32'hdeadbeef, v, e);
    doRead(12'hFFC, d, v, e);
    check("R10 read top of window", d, 0);
    doRead(12'h004, d, v, e);
    check("R10 aliased write dropped", d, 32'h12345678);
    check("R12 err clears after legal read", 32'(e), 0);
  endtask

  task automatic testUnaligned();
    logic [31:0] d; logic v, e;
    doWrite(12'h005, 32'hdeadbeef, v, e);
    check("R11 unaligned write err", 32'(e), 1);
    doRead(12'h004, d, v, e);
    check("R11 unaligned write dropped", d, 32'h12345678);
    doRead(12'h006, d, v, e);
    check("R11 unaligned read data", d, 0);
    check("R11 unaligned read err", 32'(e), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlainRw();
    testSwReset();
    testPll();
    testTicks();
    testSeconds();
    testReadOnly();
    testOutOfRange();
    testUnaligned();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule